// File: doc/BRIEF.md
# Comparator control and edge-flag register

This block is the digital side of an analog voltage comparator. One 8-bit control and status register sits on a simple peripheral write/read port. The register holds an enable bit, a read-only view of the live comparator result, two sticky edge flags, and two 2-bit hysteresis selects. The enable bit and the hysteresis selects drive the analog trim directly. The raw comparator output passes through a synchroniser, and its transitions are turned into rising and falling flags. Each flag drives its own interrupt request.

Changing the analog operating point can make the comparator chatter. Turning it on has the same effect. To stop that noise from leaving stale flags, a blanking timer runs for a programmable number of clocks after the block is enabled. It also runs after any write that alters a hysteresis select. While the timer runs, edge detection is held off.

The block also asks the oscillator to leave suspend while the comparator is on and its result is low.

Top module: `cmpx_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and `ana_en`, `hyst_pos`, `hyst_neg`, `irq_rise`, `irq_fall` and `osc_wake` are all 0.
- R2: The register layout is fixed as follows. Bit 7 is enable, bit 6 is the comparator result, bit 5 is the rising flag and bit 4 is the falling flag. Bits 3:2 are the positive hysteresis select and bits 1:0 the negative one. A write loads bit 7 and bits 3:0 one clock later. These fields are readable and appear unchanged on `ana_en`, `hyst_pos` and `hyst_neg`. Each select is coded 00 off, 01 5 mV, 10 10 mV, 11 20 mV.
- R3: While enabled, bit 6 shows `cmp_raw` after a two-flop synchroniser, so it follows a change two clocks later. While disabled, bit 6 reads 0. A write to bit 6 has no effect.
- R4: A 0-to-1 change of the synchronised result sets the rising flag; the flag is set one clock after bit 6 rises. The flag stays set until a write puts 0 in bit 5. A write of 1 to bit 5 sets it.
- R5: A 1-to-0 change of the synchronised result sets the falling flag, with the same timing as R4. The flag stays set until a write puts 0 in bit 4. A write of 1 to bit 4 sets it.
- R6: When a write clearing a flag falls in the same clock as a new edge of that type, the flag stays set.
- R7: A write that turns enable from 0 to 1 starts a blanking window of `BLANK_CYCLES` clocks. An edge whose detection clock falls inside the window sets no flag. The first detection clock outside the window is `BLANK_CYCLES`+1 clocks after the write.
- R8: A write that changes bits 3:0 restarts the same window. A write that leaves bits 3:0 unchanged does not start it.
- R9: While disabled, changes of `cmp_raw` set no flag.
- R10: `osc_wake` is 1 exactly when the block is enabled and bit 6 reads 0.
- R11: `irq_rise` equals the rising flag and `irq_fall` equals the falling flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register contents |
| cmp_raw | input | 1 | Asynchronous comparator result from the analog block |
| ana_en | output | 1 | Comparator power enable to the analog block |
| hyst_pos | output | 2 | Positive hysteresis select to the analog block |
| hyst_neg | output | 2 | Negative hysteresis select to the analog block |
| irq_rise | output | 1 | Rising-edge interrupt request |
| irq_fall | output | 1 | Falling-edge interrupt request |
| osc_wake | output | 1 | Request to wake the oscillator from suspend |

## Verification
The bench probes the blanking window at its exact edge. One case moves the input one clock before the window ends, and another moves it on the first clock after. A counter that is one clock short or one clock long therefore sets a flag that should stay clear, or misses one it should catch. A write that rewrites bits 3:0 with the same value must leave edges visible; a design that blanks on every write would lose that edge. The bench also times a flag-clear write onto the exact clock of a new edge. A design where the clear wins drops that event. Toggling the input while disabled shows whether the block leaks flags or wake requests when it is off.

// File: rtl/cmpx_pkg.sv
package cmpx_pkg;

  // Register field positions (software and the bench decode these)
  localparam int unsigned BIT_EN   = 7;
  localparam int unsigned BIT_OUT  = 6;
  localparam int unsigned BIT_RISE = 5;
  localparam int unsigned BIT_FALL = 4;
  localparam int unsigned HYST_W   = 2;

  typedef struct packed {
    logic              en;
    logic              out;
    logic              rise;
    logic              fall;
    logic [HYST_W-1:0] hpos;
    logic [HYST_W-1:0] hneg;
  } cmpx_reg_t;

  // Next value of a sticky flag: a new event beats a software write.
  function automatic logic flag_next(input logic cur, input logic evt,
                                     input logic wr, input logic wbit);
    if (evt)      return 1'b1;
    else if (wr)  return wbit;
    else          return cur;
  endfunction

  // Whether a write must (re)start the blanking window.
  function automatic logic blank_needed(input logic wr, input logic [7:0] wdata,
                                        input logic en_now,
                                        input logic [2*HYST_W-1:0] hyst_now);
    logic turn_on;
    logic trim_chg;
    turn_on  = wdata[BIT_EN] && !en_now;
    trim_chg = wdata[2*HYST_W-1:0] != hyst_now;
    return wr && (turn_on || trim_chg);
  endfunction

  // Load value of the blanking counter.
  function automatic int unsigned blank_load(input int unsigned cycles);
    return cycles;
  endfunction

endpackage

// File: rtl/cmpx_sync.sv
module cmpx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cmpx_blank.sv
module cmpx_blank #(
  parameter int unsigned BLANK_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int unsigned CNT_W = $clog2(BLANK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(cmpx_pkg::blank_load(BLANK_CYCLES));

  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign active   = !cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (start)     cnt_q <= LOAD_V;
    else if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD_V); // R7
  AST_BLANK_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active); // R7

endmodule

// File: rtl/cmpx_edge.sv
module cmpx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic enable,
  input  logic blank,
  input  logic wr,
  input  logic wr_rise,
  input  logic wr_fall,
  output logic rise_evt,
  output logic fall_evt,
  output logic rise_flag,
  output logic fall_flag
);
  import cmpx_pkg::*;

  logic prev_q;
  logic armed;

  assign armed    = enable && !blank;
  assign rise_evt = armed && level && !prev_q;
  assign fall_evt = armed && !level && prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_flag <= 1'b0;
      fall_flag <= 1'b0;
    end else begin
      rise_flag <= flag_next(rise_flag, rise_evt, wr, wr_rise);
      fall_flag <= flag_next(fall_flag, fall_evt, wr, wr_fall);
    end
  end

  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> rise_flag); // R4
  AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> fall_flag); // R5
  AST_RISE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rise_flag && !wr |=> rise_flag); // R4
  AST_FALL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fall_flag && !wr |=> fall_flag); // R5
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && wr && !wr_fall) |=> fall_flag); // R6

endmodule

// File: rtl/cmpx_ctrl.sv
module cmpx_ctrl #(
  parameter int unsigned BLANK_CYCLES = 16,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       cmp_raw,
  output logic       ana_en,
  output logic [1:0] hyst_pos,
  output logic [1:0] hyst_neg,
  output logic       irq_rise,
  output logic       irq_fall,
  output logic       osc_wake
);
  import cmpx_pkg::*;

  localparam int unsigned TRIM_W = 2 * HYST_W;

  logic              en_q;
  logic [TRIM_W-1:0] trim_q;
  logic              sync_lvl;
  logic              live_out;
  logic              blank_start;
  logic              blank_act;
  logic              rise_evt;
  logic              fall_evt;
  logic              rise_flag;
  logic              fall_flag;
  cmpx_reg_t         view;

  // Control fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      trim_q <= '0;
    end else if (wr_en) begin
      en_q   <= wr_data[BIT_EN];
      trim_q <= wr_data[TRIM_W-1:0];
    end
  end

  assign blank_start = blank_needed(wr_en, wr_data, en_q, trim_q);

  cmpx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cmp_raw),
    .q     (sync_lvl)
  );

  cmpx_blank #(.BLANK_CYCLES(BLANK_CYCLES)) blank_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (blank_start),
    .active (blank_act)
  );

  cmpx_edge edge_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (sync_lvl),
    .enable    (en_q),
    .blank     (blank_act),
    .wr        (wr_en),
    .wr_rise   (wr_data[BIT_RISE]),
    .wr_fall   (wr_data[BIT_FALL]),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .rise_flag (rise_flag),
    .fall_flag (fall_flag)
  );

  assign live_out = en_q && sync_lvl;

  always_comb begin
    view.en   = en_q;
    view.out  = live_out;
    view.rise = rise_flag;
    view.fall = fall_flag;
    view.hpos = trim_q[TRIM_W-1:HYST_W];
    view.hneg = trim_q[HYST_W-1:0];
  end

  assign rd_data  = view;
  assign ana_en   = en_q;
  assign hyst_pos = view.hpos;
  assign hyst_neg = view.hneg;
  assign irq_rise = rise_flag;
  assign irq_fall = fall_flag;
  assign osc_wake = en_q && !sync_lvl;

  AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    blank_act && !wr_en |=> $stable(rise_flag) && $stable(fall_flag)); // R7
  AST_TRIM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_data[TRIM_W-1:0] != {hyst_pos, hyst_neg}) |=> blank_act); // R8
  AST_ENABLE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[BIT_EN] && !ana_en |=> blank_act); // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ana_en && !wr_en |=> $stable(rise_flag) && $stable(fall_flag)); // R9
  AST_WAKE_ONLY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    osc_wake |-> ana_en && !rd_data[BIT_OUT]); // R10
  AST_OFF_READS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ana_en |-> !rd_data[BIT_OUT]); // R3

endmodule

// File: tb/cmpx_ctrl_tb.sv
`timescale 1ns/1ps
module cmpx_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       cmp_raw = 1'b0;
  logic       ana_en;
  logic [1:0] hyst_pos;
  logic [1:0] hyst_neg;
  logic       irq_rise;
  logic       irq_fall;
  logic       osc_wake;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cmpx_ctrl #(.BLANK_CYCLES(16), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cmp_raw(cmp_raw), .ana_en(ana_en),
    .hyst_pos(hyst_pos), .hyst_neg(hyst_neg), .irq_rise(irq_rise),
    .irq_fall(irq_fall), .osc_wake(osc_wake)
  );

  // Entry: {req[28:25], wr[24], wdata[23:16], raw[15], ncyc[14:9], exp_rd[8:1], exp_wake[0]}
  localparam int NV = 15;
  localparam logic [28:0] VEC [0:NV-1] = '{
    {4'd2,  1'b1, 8'h86, 1'b0, 6'd20, 8'h86, 1'b1}, // R2 R10 enable, trims
    {4'd4,  1'b0, 8'h00, 1'b1, 6'd3,  8'hE6, 1'b0}, // R4 rise sets
    {4'd5,  1'b0, 8'h00, 1'b0, 6'd3,  8'hB6, 1'b1}, // R5 fall sets
    {4'd4,  1'b1, 8'h86, 1'b0, 6'd2,  8'h86, 1'b1}, // R4 clear both
    {4'd3,  1'b1, 8'hF6, 1'b0, 6'd2,  8'hB6, 1'b1}, // R3 bit6 ignored, flags set by write
    {4'd5,  1'b1, 8'h86, 1'b0, 6'd2,  8'h86, 1'b1}, // R5 clear
    {4'd8,  1'b1, 8'h8B, 1'b1, 6'd3,  8'hCB, 1'b0}, // R8 trim change blanks
    {4'd8,  1'b0, 8'h00, 1'b1, 6'd20, 8'hCB, 1'b0}, // R8 window ends
    {4'd8,  1'b0, 8'h00, 1'b0, 6'd3,  8'h9B, 1'b1}, // R8 edge seen after
    {4'd9,  1'b1, 8'h0B, 1'b0, 6'd2,  8'h0B, 1'b0}, // R9 disable, clear
    {4'd9,  1'b0, 8'h00, 1'b1, 6'd4,  8'h0B, 1'b0}, // R9 no rise when off
    {4'd9,  1'b0, 8'h00, 1'b0, 6'd4,  8'h0B, 1'b0}, // R9 no fall when off
    {4'd7,  1'b1, 8'h8B, 1'b1, 6'd3,  8'hCB, 1'b0}, // R7 enable blanks
    {4'd7,  1'b0, 8'h00, 1'b1, 6'd20, 8'hCB, 1'b0}, // R7 settle
    {4'd5,  1'b0, 8'h00, 1'b0, 6'd3,  8'h9B, 1'b1}  // R5 fall after window
  };

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "rd_data", rd_data, 8'h00);
    chk("R1", "outputs", {2'b0, ana_en, hyst_pos, hyst_neg, irq_rise, irq_fall, osc_wake} , 8'h00);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d", v[28:25]);
      wr_en = v[24]; wr_data = v[23:16]; cmp_raw = v[15];
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00;
      for (int k = 1; k < int'(v[14:9]); k++) @(posedge clk);
      @(negedge clk);
      chk(rq, $sformatf("step %0d rd_data", i), rd_data, v[8:1]);
      chk("R10", $sformatf("step %0d osc_wake", i), {7'b0, osc_wake}, {7'b0, v[0]});
    end

    // R2 analog fields, current value 0x9B: hpos=10 hneg=11
    chk("R2", "hyst_pos", {6'b0, hyst_pos}, 8'h02);
    chk("R2", "hyst_neg", {6'b0, hyst_neg}, 8'h03);
    chk("R2", "ana_en", {7'b0, ana_en}, 8'h01);
    chk("R11", "irq_fall follows flag", {6'b0, irq_rise, irq_fall}, 8'h01);

    // R7 boundary: edge detected one clock before window end -> blanked
    wr_reg(8'h0B);
    cmp_raw = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h8B;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
    repeat (13) @(posedge clk);
    @(negedge clk);
    cmp_raw = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R7", "edge on last blank clock", rd_data, 8'hCB);

    // R7 boundary: edge detected on first clock after window -> seen
    wr_reg(8'h0B);
    cmp_raw = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h8B;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
    repeat (14) @(posedge clk);
    @(negedge clk);
    cmp_raw = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R7", "edge on first open clock", rd_data, 8'hEB);
    chk("R11", "irq_rise follows flag", {7'b0, irq_rise}, 8'h01);

    // R4 clear, then R6 edge beats clear
    wr_reg(8'h8B);
    chk("R4", "rise cleared", rd_data, 8'hCB);
    chk("R11", "irq_rise drops", {7'b0, irq_rise}, 8'h00);
    @(negedge clk);
    cmp_raw = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h8B;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
    chk("R6", "fall kept on coincident clear", rd_data, 8'h9B);
    chk("R11", "irq_fall set", {7'b0, irq_fall}, 8'h01);
    wr_reg(8'h8B);
    chk("R5", "fall cleared", rd_data, 8'h8B);
    chk("R11", "irq_fall drops", {7'b0, irq_fall}, 8'h00);

    finish_run();
  end

endmodule